// File: doc/BRIEF.md
# Macro Result Router and Method Emitter

This block carries out the result step of every non-branch instruction in a small command macro engine. The execute stage hands it a 3-bit result mode, a destination register index and the 32-bit computed value. The mode selects what happens next. The destination register receives either the computed value or the next word taken from the parameter queue. The computed value may be loaded into the method-address register. A word may also be emitted on the method output, as a 12-bit address and a 32-bit data word.

The method-address register is 18 bits wide. Bits [11:0] hold the target address and bits [17:12] hold a step. After each emitted word, the address moves forward by that step and wraps within 12 bits, while the step stays the same. An instruction is held by its producer until the block raises a one-cycle acknowledge. That happens only when the required parameter has been taken from the queue and the required word has been accepted on the output. All register-file and address-register updates take effect in the acknowledge cycle. At program exit, the block records whether any parameter was left unconsumed.

Top module: `macro_result_router`

## Requirements
- R1: After reset, in_ack, prm_pop, mth_valid and param_left are low, and the method-address register (address and step) is zero, so the first word sent without a prior load goes to address 0.
- R2: Modes 0, 3 and 5 write the popped parameter to the destination register. Modes 1, 2, 4, 6 and 7 write in_result there. The write happens in the acknowledge cycle (rf_we high, rf_idx = in_dst).
- R3: Only modes 3, 4, 6 and 7 emit a word, exactly once per instruction. Modes 0, 1, 2 and 5 never raise mth_valid.
- R4: Modes 2, 5, 6 and 7 load in_result[17:0] into the method-address register. In modes 6 and 7 the emitted word already uses the newly loaded address and step.
- R5: Each emitted word goes to the current address. The address then advances by the step, modulo 4096, and the step is unchanged.
- R6: Emitted data is in_result for modes 3 and 4, the popped parameter for mode 6, and in_result[17:12] zero-extended for mode 7.
- R7: Modes 0, 3, 5 and 6 pop exactly one parameter each and other modes pop none, so parameters are consumed in queue order.
- R8: While a needed parameter is missing (prm_valid low), in_ack stays low and nothing is written. A mode-6 word is not offered before its parameter is present.
- R9: While mth_valid is high and mth_ready is low, in_ack stays low, mth_valid stays high, and the address register does not advance.
- R10: One cycle after a prog_exit pulse, param_left equals prm_valid as sampled with the pulse. It holds that value until the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present, held until in_ack |
| in_mode | input | 3 | Result mode (instruction bits [6:4]) |
| in_dst | input | 3 | Destination register index |
| in_result | input | 32 | Computed value from the execute stage |
| in_ack | output | 1 | Instruction completed this cycle |
| prm_valid | input | 1 | Parameter queue not empty |
| prm_data | input | 32 | Head of the parameter queue |
| prm_pop | output | 1 | Take the head of the parameter queue |
| rf_we | output | 1 | Register-file write enable |
| rf_idx | output | 3 | Register-file write index |
| rf_wdata | output | 32 | Register-file write data |
| mth_valid | output | 1 | Method word offered |
| mth_ready | input | 1 | Method word accepted |
| mth_addr | output | 12 | Method address |
| mth_data | output | 32 | Method data |
| prog_exit | input | 1 | Program-exit pulse |
| param_left | output | 1 | Parameters were left at the last exit |

## Verification
Modes 3 and 6 need both a parameter fetch and an emitted word. These two can complete in the same cycle or in different cycles. The bench first runs both with a filled queue and ready held high, where pop, emit and acknowledge must fall in one cycle. It then runs mode 3 with an empty queue, so the word is emitted first and must not be offered again; the acknowledge and the parameter write must come only when a parameter is pushed. It also runs mode 6 with an empty queue, where the word must stay withheld until the parameter arrives.

// File: rtl/macro_result_router.sv
module macro_result_router #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter int INC_W  = 6,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        in_mode,
  input  logic [IDX_W-1:0]  in_dst,
  input  logic [DATA_W-1:0] in_result,
  output logic              in_ack,
  input  logic              prm_valid,
  input  logic [DATA_W-1:0] prm_data,
  output logic              prm_pop,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_idx,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              mth_valid,
  input  logic              mth_ready,
  output logic [ADDR_W-1:0] mth_addr,
  output logic [DATA_W-1:0] mth_data,
  input  logic              prog_exit,
  output logic              param_left
);
  localparam int MA_W = ADDR_W + INC_W;

  logic [MA_W-1:0]   areg;
  logic              f_done, s_done;
  logic [DATA_W-1:0] p_hold;

  // mode decode
  logic need_fetch, need_send, set_addr, wr_param;
  assign need_fetch = (in_mode == 3'd0) || (in_mode == 3'd3) || (in_mode == 3'd5) || (in_mode == 3'd6);
  assign need_send  = (in_mode == 3'd3) || (in_mode == 3'd4) || (in_mode == 3'd6) || (in_mode == 3'd7);
  assign set_addr   = (in_mode == 3'd2) || (in_mode == 3'd5) || (in_mode == 3'd6) || (in_mode == 3'd7);
  assign wr_param   = (in_mode == 3'd0) || (in_mode == 3'd3) || (in_mode == 3'd5);

  logic [MA_W-1:0]   eff_ma, adv_ma;
  logic [DATA_W-1:0] pval;
  logic              p_avail, fetch_ok, send_ok, fire;

  assign eff_ma  = set_addr ? in_result[MA_W-1:0] : areg;
  assign adv_ma  = {eff_ma[MA_W-1:ADDR_W], eff_ma[ADDR_W-1:0] + ADDR_W'(eff_ma[MA_W-1:ADDR_W])};
  assign pval    = f_done ? p_hold : prm_data;
  assign p_avail = f_done || prm_valid;

  assign prm_pop   = in_valid && need_fetch && !f_done && prm_valid;
  assign mth_valid = in_valid && need_send && !s_done && ((in_mode != 3'd6) || p_avail);
  assign mth_addr  = eff_ma[ADDR_W-1:0];
  assign mth_data  = (in_mode == 3'd7) ? DATA_W'(in_result[MA_W-1:ADDR_W]) :
                     (in_mode == 3'd6) ? pval : in_result;

  assign fire     = mth_valid && mth_ready;
  assign fetch_ok = !need_fetch || p_avail;
  assign send_ok  = !need_send || s_done || fire;
  assign in_ack   = in_valid && fetch_ok && send_ok;

  assign rf_we    = in_ack;
  assign rf_idx   = in_dst;
  assign rf_wdata = wr_param ? pval : in_result;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      areg   <= '0;
      f_done <= 1'b0;
      s_done <= 1'b0;
      p_hold <= '0;
      param_left <= 1'b0;
    end else begin
      if (in_ack) begin
        f_done <= 1'b0;
        s_done <= 1'b0;
        if (need_send)     areg <= adv_ma;
        else if (set_addr) areg <= in_result[MA_W-1:0];
      end else begin
        if (prm_pop) begin
          f_done <= 1'b1;
          p_hold <= prm_data;
        end
        if (fire) s_done <= 1'b1;
      end
      if (prog_exit) param_left <= prm_valid;
    end
  end

  a_r8_stall_queue: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && need_fetch && !f_done && !prm_valid |-> !in_ack && !rf_we);
  a_r8_no_early_word: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_mode == 3'd6 && !f_done && !prm_valid |-> !mth_valid);
  a_r9_hold_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mth_valid && !mth_ready |-> !in_ack);
  a_r9_areg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ack |=> $stable(areg));
  a_r3_single_word: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !in_ack |=> !mth_valid);
  a_r7_single_pop: assert property (@(posedge clk) disable iff (!rst_n)
    prm_pop && !in_ack |=> !prm_pop);
  a_r5_advance: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_ack && !set_addr |=>
      areg[ADDR_W-1:0] == $past(areg[ADDR_W-1:0] + ADDR_W'(areg[MA_W-1:ADDR_W])) &&
      areg[MA_W-1:ADDR_W] == $past(areg[MA_W-1:ADDR_W]));
  a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
    in_ack && set_addr && !need_send |=> areg == $past(in_result[MA_W-1:0]));
  a_r10_left: assert property (@(posedge clk) disable iff (!rst_n)
    prog_exit |=> param_left == $past(prm_valid));
endmodule

// File: tb/macro_result_router_tb.sv
module macro_result_router_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  in_mode = '0;
  logic [2:0]  in_dst = '0;
  logic [31:0] in_result = '0;
  logic        in_ack;
  logic        prm_valid;
  logic [31:0] prm_data;
  logic        prm_pop;
  logic        rf_we;
  logic [2:0]  rf_idx;
  logic [31:0] rf_wdata;
  logic        mth_valid;
  logic        mth_ready = 1'b1;
  logic [11:0] mth_addr;
  logic [31:0] mth_data;
  logic        prog_exit = 1'b0;
  logic        param_left;

  always #4 clk = ~clk;

  macro_result_router u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode), .in_dst(in_dst),
    .in_result(in_result), .in_ack(in_ack), .prm_valid(prm_valid), .prm_data(prm_data),
    .prm_pop(prm_pop), .rf_we(rf_we), .rf_idx(rf_idx), .rf_wdata(rf_wdata),
    .mth_valid(mth_valid), .mth_ready(mth_ready), .mth_addr(mth_addr), .mth_data(mth_data),
    .prog_exit(prog_exit), .param_left(param_left)
  );

  // parameter queue model
  logic [31:0] q [16];
  logic [3:0]  wp = '0;
  logic [3:0]  rp = '0;
  assign prm_valid = (wp != rp);
  assign prm_data  = q[rp];
  always @(posedge clk) if (prm_pop) rp <= rp + 4'd1;

  int errors = 0;
  int checks = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] d);
    q[wp] = d;
    wp = wp + 4'd1;
  endtask

  // vector table
  localparam int N = 12;
  localparam logic [2:0]  T_MODE [N] = '{3'd4, 3'd2, 3'd4, 3'd3, 3'd0, 3'd1, 3'd5, 3'd4, 3'd6, 3'd7, 3'd4, 3'd3};
  localparam logic [2:0]  T_DST  [N] = '{3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5};
  localparam logic [31:0] T_RES  [N] = '{32'h11110000, 32'h00003010, 32'hAAAA5555, 32'h12345678,
                                         32'hDEADBEEF, 32'h00000042, 32'h00010FFE, 32'h00000007,
                                         32'h00021100, 32'h0003F7F0, 32'h00000099, 32'h00000055};
  localparam logic [31:0] T_WD   [N] = '{32'h11110000, 32'h00003010, 32'hAAAA5555, 32'hCAFE0001,
                                         32'h0BAD0002, 32'h00000042, 32'h00000003, 32'h00000007,
                                         32'h00021100, 32'h0003F7F0, 32'h00000099, 32'h00000005};
  localparam logic        T_SND  [N] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
  localparam logic        T_POP  [N] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam logic [11:0] T_ADDR [N] = '{12'h000, 12'h000, 12'h010, 12'h013, 12'h000, 12'h000,
                                         12'h000, 12'hFFE, 12'h100, 12'h7F0, 12'h82F, 12'h86E};
  localparam logic [31:0] T_DATA [N] = '{32'h11110000, 32'h0, 32'hAAAA5555, 32'h12345678, 32'h0, 32'h0,
                                         32'h0, 32'h00000007, 32'h44440004, 32'h0000003F, 32'h00000099,
                                         32'h00000055};

  task automatic present(input logic [2:0] m, input logic [2:0] d, input logic [31:0] r);
    in_mode = m; in_dst = d; in_result = r; in_valid = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #2;
    // R1 outputs during reset
    chk("R1 ack", {31'b0, in_ack}, 32'd0);
    chk("R1 pop", {31'b0, prm_pop}, 32'd0);
    chk("R1 valid", {31'b0, mth_valid}, 32'd0);
    chk("R1 left", {31'b0, param_left}, 32'd0);
    rst_n = 1'b1;
    push(32'hCAFE0001); push(32'h0BAD0002); push(32'h00000003);
    push(32'h44440004); push(32'h00000005);

    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      present(T_MODE[i], T_DST[i], T_RES[i]);
      #2;
      chk($sformatf("R2 v%0d ack", i), {31'b0, in_ack}, 32'd1);
      chk($sformatf("R2 v%0d we", i), {31'b0, rf_we}, 32'd1);
      chk($sformatf("R2 v%0d idx", i), {29'b0, rf_idx}, {29'b0, T_DST[i]});
      chk($sformatf("R2 v%0d wdata", i), rf_wdata, T_WD[i]);
      chk($sformatf("R3 v%0d send", i), {31'b0, mth_valid}, {31'b0, T_SND[i]});
      chk($sformatf("R7 v%0d pop", i), {31'b0, prm_pop}, {31'b0, T_POP[i]});
      if (T_SND[i]) begin
        chk($sformatf("R5 v%0d addr", i), {20'b0, mth_addr}, {20'b0, T_ADDR[i]});
        chk($sformatf("R6 v%0d data", i), mth_data, T_DATA[i]);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    prog_exit = 1'b1;
    @(negedge clk);
    prog_exit = 1'b0;
    #2;
    chk("R10 empty at exit", {31'b0, param_left}, 32'd0);

    // R8 stall on empty queue, mode 0
    @(negedge clk);
    present(3'd0, 3'd1, 32'h0);
    #2;
    for (int k = 0; k < 3; k++) begin
      chk("R8 stall ack", {31'b0, in_ack}, 32'd0);
      chk("R8 stall we", {31'b0, rf_we}, 32'd0);
      @(negedge clk); #2;
    end
    push(32'h00000077);
    #1;
    chk("R8 resume ack", {31'b0, in_ack}, 32'd1);
    chk("R8 resume wdata", rf_wdata, 32'h00000077);

    // R9 backpressure, mode 4 at 0x8AD
    @(negedge clk);
    mth_ready = 1'b0;
    present(3'd4, 3'd2, 32'h00000123);
    #2;
    for (int k = 0; k < 2; k++) begin
      chk("R9 valid held", {31'b0, mth_valid}, 32'd1);
      chk("R9 no ack", {31'b0, in_ack}, 32'd0);
      chk("R9 addr", {20'b0, mth_addr}, 32'h8AD);
      @(negedge clk); #2;
    end
    mth_ready = 1'b1;
    #1;
    chk("R9 ack on ready", {31'b0, in_ack}, 32'd1);

    // mode 3 with empty queue: word first, parameter later
    @(negedge clk);
    present(3'd3, 3'd3, 32'h00000ABC);
    #2;
    chk("R5 mode3 addr", {20'b0, mth_addr}, 32'h8EC);
    chk("R3 mode3 word", {31'b0, mth_valid}, 32'd1);
    chk("R8 mode3 wait", {31'b0, in_ack}, 32'd0);
    @(negedge clk); #2;
    chk("R3 no repeat", {31'b0, mth_valid}, 32'd0);
    chk("R8 still wait", {31'b0, in_ack}, 32'd0);
    push(32'h00000088);
    #1;
    chk("R2 mode3 ack", {31'b0, in_ack}, 32'd1);
    chk("R2 mode3 wdata", rf_wdata, 32'h00000088);

    // mode 6 with empty queue
    @(negedge clk);
    present(3'd6, 3'd4, 32'h00001FF0);
    #2;
    chk("R8 mode6 withheld", {31'b0, mth_valid}, 32'd0);
    @(negedge clk);
    push(32'h00000099);
    #2;
    chk("R6 mode6 valid", {31'b0, mth_valid}, 32'd1);
    chk("R6 mode6 data", mth_data, 32'h00000099);
    chk("R4 mode6 addr", {20'b0, mth_addr}, 32'hFF0);
    chk("R2 mode6 wdata", rf_wdata, 32'h00001FF0);
    chk("R7 mode6 pop", {31'b0, prm_pop}, 32'd1);

    @(negedge clk);
    present(3'd4, 3'd5, 32'h00000005);
    #2;
    chk("R5 step 1", {20'b0, mth_addr}, 32'hFF1);

    // R10 leftover parameter
    @(negedge clk);
    in_valid = 1'b0;
    push(32'h00000001);
    prog_exit = 1'b1;
    @(negedge clk);
    prog_exit = 1'b0;
    #2;
    chk("R10 leftover", {31'b0, param_left}, 32'd1);
    @(negedge clk);
    present(3'd0, 3'd6, 32'h0);
    #2;
    chk("R7 drain pop", {31'b0, prm_pop}, 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    prog_exit = 1'b1;
    @(negedge clk);
    prog_exit = 1'b0;
    #2;
    chk("R10 cleared", {31'b0, param_left}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule